// File: doc/BRIEF.md
# Weighted Timer Channel Service Scheduler

This block decides which of sixteen timer channels a single shared service engine works on next. Each channel carries a pending-request latch. An external channel event sets it, and so does a host write to the service-request register. Each channel also has a host-programmed two-bit priority code. Three codes select the levels low, middle and high. The fourth code switches the channel off, and a channel that is off is never granted service.

Service is handed out in slots. One round is seven slots long, in the fixed order high, middle, high, low, high, middle, high, so the high level holds four of every seven slots, the middle level two and the low level one. A slot whose level has nothing pending goes to the first level with a pending request, searching high, then middle, then low. Within a level, channels take turns in round-robin order.

The grant is held until the engine pulses its done strobe. The done strobe clears the served channel's latch. If that channel has interrupts enabled, the done strobe also sets the channel's interrupt status bit. Any set status bit raises an interrupt request. Its vector combines a programmable upper nibble with the number of the lowest-numbered channel whose status is set.

Top module: `timerSched`

## Requirements
- R1: After reset the following hold: grantValid is 0, irqValid is 0 and intStatus is all zero. Every priority code is 00, the interrupt enables are all 0 and the base nibble is 0.
- R2: Priority code 00 disables a channel, and a disabled channel is never granted. Its pending latch is kept, so the channel is served once it is given a nonzero code. Codes are 01 low, 10 middle and 11 high. Register 0 holds channels 0 to 7, and register 1 holds channels 8 to 15. Channel c sits at bits [2(c mod 8)+1 : 2(c mod 8)].
- R3: Slots run in a seven-slot round in the order high, middle, high, low, high, middle, high. The slot position advances only when a grant is issued. With every level pending, any 14 consecutive grants therefore contain 8 high, 4 middle and 2 low.
- R4: When the level assigned to the current slot has no eligible pending channel, the grant goes to the first level with one, searching high, then middle, then low. No grant is issued when no channel is eligible.
- R5: Within a level, the granted channel is the first eligible channel after the one last granted at that level, wrapping from 15 to 0. Before the first grant at a level, the search starts at channel 0.
- R6: A channel's pending latch is set by a 1 on its chanEvent bit, or by a host write of a 1 to its bit of register 2. A set and a done-strobe clear in the same cycle leave the latch set.
- R7: A grant appears on grantValid and grantChan on the clock edge that samples an eligible request while no grant is held. It stays stable until doneStb is high at a clock edge. grantValid drops on that edge, and a new grant can appear at the following edge at the earliest.
- R8: On the done edge, the served channel's intStatus bit is set if its enable bit (register 3) is 1. Writing a 1 to a bit of register 4 clears that bit. A set wins over a clear in the same cycle.
- R9: irqValid is 1 exactly when any intStatus bit is set. irqVector[7:4] is the nibble written to register 5, bits [3:0], and irqVector[3:0] is the lowest-numbered channel whose status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chanEvent | input | 16 | Per-channel event pulses that set pending latches |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register select (0..5) |
| wrData | input | 16 | Register write data |
| doneStb | input | 1 | Service engine finished the granted channel |
| grantValid | output | 1 | A grant is being held |
| grantChan | output | 4 | Granted channel number |
| irqValid | output | 1 | At least one interrupt status bit is set |
| irqVector | output | 8 | Interrupt vector: base nibble and channel number |
| intStatus | output | 16 | Per-channel interrupt status bits |

## Verification
Each internal fault shows up at the ports at a predictable point:
- A wrong slot position or a wrong round-robin pointer shows as the wrong channel number on the very next grant after the divergence.
- A lost or stale pending latch shows up within one round, as a grant that is missing or extra.
- An interrupt status error shows on intStatus and irqVector one cycle after the done strobe or the clearing write.

The bench runs a cycle-level model of the latches, slots and pointers and compares every output after each clock. It also counts the per-level grant mix across two full rounds under saturating load.

// File: rtl/timerSchedPkg.sv
package timerSchedPkg;
  localparam int ROUND_LEN = 7;
  localparam int A_PRIO_LO = 0;
  localparam int A_PRIO_HI = 1;
  localparam int A_HOSTREQ = 2;
  localparam int A_INTEN = 3;
  localparam int A_INTCLR = 4;
  localparam int A_BASE = 5;

  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_MID  = 2'b10,
    LVL_HIGH = 2'b11
  } prioLvlT;

  typedef struct packed {
    logic       grantLoad;
    logic [1:0] level;
    logic       doneAck;
  } ctrlStbT;
endpackage

// File: rtl/timerSchedCtrl.sv
module timerSchedCtrl
  import timerSchedPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] levelHas,
  input  logic       doneStb,
  output logic       grantValid,
  output ctrlStbT    ctrlStb
);
  localparam int SLOT_W = $clog2(ROUND_LEN);

  logic [SLOT_W-1:0] slotQ;
  logic              busyQ;
  logic [1:0]        slotLvl;
  logic [1:0]        chosenLvl;
  logic              anyReq;

  function automatic logic [1:0] slotLevel(input logic [SLOT_W-1:0] s);
    case (s)
      SLOT_W'(1), SLOT_W'(5): slotLevel = LVL_MID;
      SLOT_W'(3):             slotLevel = LVL_LOW;
      default:                slotLevel = LVL_HIGH;
    endcase
  endfunction

  always_comb begin
    slotLvl = slotLevel(slotQ);
    anyReq  = |levelHas[3:1];
    if (levelHas[slotLvl])      chosenLvl = slotLvl;
    else if (levelHas[LVL_HIGH]) chosenLvl = LVL_HIGH;
    else if (levelHas[LVL_MID])  chosenLvl = LVL_MID;
    else if (levelHas[LVL_LOW])  chosenLvl = LVL_LOW;
    else                         chosenLvl = LVL_OFF;
  end

  always_comb begin
    ctrlStb.grantLoad = !busyQ && anyReq;
    ctrlStb.level     = chosenLvl;
    ctrlStb.doneAck   = busyQ && doneStb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      slotQ <= '0;
    end else begin
      if (ctrlStb.grantLoad) begin
        busyQ <= 1'b1;
        slotQ <= (slotQ == SLOT_W'(ROUND_LEN - 1)) ? '0 : slotQ + 1'b1;
      end else if (ctrlStb.doneAck) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign grantValid = busyQ;
endmodule

// File: rtl/timerSchedDp.sv
module timerSchedDp
  import timerSchedPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chanEvent,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NUM_CH-1:0] wrData,
  input  ctrlStbT           ctrlStb,
  output logic [3:0]        levelHas,
  output logic [CH_W-1:0]   grantChan,
  output logic [NUM_CH-1:0] intStatus,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector
);
  localparam int BASE_W = VEC_W - CH_W;
  localparam int CPW    = NUM_CH / 2;

  logic [2*NUM_CH-1:0] prioQ;
  logic [NUM_CH-1:0]   pendQ;
  logic [NUM_CH-1:0]   intEnQ;
  logic [NUM_CH-1:0]   intStQ;
  logic [BASE_W-1:0]   baseQ;
  logic [CH_W-1:0]     grantChanQ;
  logic [CH_W-1:0]     lastQ [4];
  logic [CH_W-1:0]     pick  [4];
  logic [NUM_CH-1:0]   setMask, clrMask, intSet, intClr;
  logic [CH_W-1:0]     lowIdx;

  function automatic logic [CH_W-1:0] rrPick(input logic [NUM_CH-1:0] req,
                                             input logic [CH_W-1:0] last);
    logic found;
    int   idx;
    rrPick = last;
    found  = 1'b0;
    for (int i = 1; i <= NUM_CH; i++) begin
      idx = (int'(last) + i) % NUM_CH;
      if (!found && req[idx]) begin
        rrPick = CH_W'(idx);
        found  = 1'b1;
      end
    end
  endfunction

  assign levelHas[0] = 1'b0;
  assign pick[0]     = '0;

  for (genvar lv = 1; lv < 4; lv++) begin : g_lvl
    logic [NUM_CH-1:0] elig;
    always_comb begin
      for (int c = 0; c < NUM_CH; c++)
        elig[c] = pendQ[c] && (prioQ[2*c +: 2] == 2'(lv));
    end
    assign levelHas[lv] = |elig;
    assign pick[lv]     = rrPick(elig, lastQ[lv]);
  end

  always_comb begin
    setMask = chanEvent;
    if (wrEn && wrAddr == ADDR_W'(A_HOSTREQ)) setMask = setMask | wrData;
    clrMask = ctrlStb.doneAck ? (NUM_CH'(1) << grantChanQ) : '0;
    intSet  = (ctrlStb.doneAck && intEnQ[grantChanQ]) ? (NUM_CH'(1) << grantChanQ) : '0;
    intClr  = (wrEn && wrAddr == ADDR_W'(A_INTCLR)) ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prioQ      <= '0;
      pendQ      <= '0;
      intEnQ     <= '0;
      intStQ     <= '0;
      baseQ      <= '0;
      grantChanQ <= '0;
      for (int l = 0; l < 4; l++) lastQ[l] <= CH_W'(NUM_CH - 1);
    end else begin
      pendQ  <= (pendQ & ~clrMask) | setMask;
      intStQ <= (intStQ & ~intClr) | intSet;
      if (wrEn) begin
        for (int c = 0; c < NUM_CH; c++)
          if (wrAddr == ADDR_W'(c / CPW)) prioQ[2*c +: 2] <= wrData[2*(c % CPW) +: 2];
        if (wrAddr == ADDR_W'(A_INTEN)) intEnQ <= wrData;
        if (wrAddr == ADDR_W'(A_BASE))  baseQ  <= wrData[BASE_W-1:0];
      end
      if (ctrlStb.grantLoad) begin
        grantChanQ           <= pick[ctrlStb.level];
        lastQ[ctrlStb.level] <= pick[ctrlStb.level];
      end
    end
  end

  always_comb begin
    lowIdx = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (intStQ[c]) lowIdx = CH_W'(c);
  end

  assign grantChan = grantChanQ;
  assign intStatus = intStQ;
  assign irqValid  = |intStQ;
  assign irqVector = {baseQ, lowIdx};
endmodule

// File: rtl/timerSched.sv
module timerSched
  import timerSchedPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] chanEvent,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [NUM_CH-1:0] wrData,
  input  logic              doneStb,
  output logic              grantValid,
  output logic [$clog2(NUM_CH)-1:0] grantChan,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector,
  output logic [NUM_CH-1:0] intStatus
);
  localparam int CH_W = $clog2(NUM_CH);

  ctrlStbT    ctrlStb;
  logic [3:0] levelHas;

  timerSchedCtrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .levelHas   (levelHas),
    .doneStb    (doneStb),
    .grantValid (grantValid),
    .ctrlStb    (ctrlStb)
  );

  timerSchedDp #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .VEC_W  (VEC_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .chanEvent (chanEvent),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .ctrlStb   (ctrlStb),
    .levelHas  (levelHas),
    .grantChan (grantChan),
    .intStatus (intStatus),
    .irqValid  (irqValid),
    .irqVector (irqVector)
  );
endmodule

// File: rtl/timerSchedChecker.sv
module timerSchedChecker
  import timerSchedPkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int VEC_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      doneStb,
  input logic                      grantValid,
  input logic [$clog2(NUM_CH)-1:0] grantChan,
  input logic [NUM_CH-1:0]         intStatus,
  input logic                      irqValid,
  input logic [VEC_W-1:0]          irqVector,
  input ctrlStbT                   ctrlStb,
  input logic [3:0]                levelHas
);
  localparam int CH_W = $clog2(NUM_CH);

  // R7: a held grant keeps its channel until the done strobe
  p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !doneStb) |=> (grantValid && $stable(grantChan)));

  // R7: the done strobe releases the grant on the next edge
  p_done_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && doneStb) |=> !grantValid);

  // R7: a new grant is only loaded while none is held
  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStb.grantLoad |-> !grantValid);

  // R4: the control picks only a level that the datapath reports as pending
  p_level_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStb.grantLoad |-> (levelHas[ctrlStb.level] && ctrlStb.level != 2'b00));

  // R8: status bits rise only after a done strobe
  p_status_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !doneStb |=> ((intStatus & ~$past(intStatus)) == '0));

  // R9: the vector names a set status bit with no lower one set
  p_vector_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irqValid |-> (intStatus[irqVector[CH_W-1:0]] &&
                  ((intStatus & ((NUM_CH'(1) << irqVector[CH_W-1:0]) - NUM_CH'(1))) == '0)));
endmodule

bind timerSched timerSchedChecker #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .doneStb    (doneStb),
  .grantValid (grantValid),
  .grantChan  (grantChan),
  .intStatus  (intStatus),
  .irqValid   (irqValid),
  .irqVector  (irqVector),
  .ctrlStb    (ctrlStb),
  .levelHas   (levelHas)
);

// File: tb/timerSched_bench.sv
`timescale 1ns/1ps
module timerSched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chanEvent = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        doneStb = 1'b0;
  logic        grantValid;
  logic [3:0]  grantChan;
  logic        irqValid;
  logic [7:0]  irqVector;
  logic [15:0] intStatus;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [15:0] mPend, mIntEn, mIntSt;
  logic [1:0]  mPrio [16];
  logic [3:0]  mBase;
  bit          mBusy;
  int          mChan, mSlot;
  int          mLast [4];

  always #5 clk = ~clk;

  timerSched u_timerSched (
    .clk(clk), .rst_n(rst_n), .chanEvent(chanEvent), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .doneStb(doneStb),
    .grantValid(grantValid), .grantChan(grantChan), .irqValid(irqValid),
    .irqVector(irqVector), .intStatus(intStatus)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int slotLvl(int s);
    if (s == 1 || s == 5) return 2;
    if (s == 3) return 1;
    return 3;
  endfunction

  function automatic int pickFrom(int lvl);
    for (int i = 1; i <= 16; i++) begin
      int c = (mLast[lvl] + i) % 16;
      if (mPend[c] && int'(mPrio[c]) == lvl) return c;
    end
    return -1;
  endfunction

  function automatic int chooseLvl();
    int a = slotLvl(mSlot);
    if (pickFrom(a) >= 0) return a;
    for (int l = 3; l >= 1; l--) if (pickFrom(l) >= 0) return l;
    return 0;
  endfunction

  function automatic logic [7:0] expVector();
    for (int c = 0; c < 16; c++) if (mIntSt[c]) return {mBase, 4'(c)};
    return {mBase, 4'h0};
  endfunction

  task automatic modelReset();
    mPend = '0; mIntEn = '0; mIntSt = '0; mBase = '0; mBusy = 0; mChan = 0; mSlot = 0;
    for (int c = 0; c < 16; c++) mPrio[c] = 2'b00;
    for (int l = 0; l < 4; l++) mLast[l] = 15;
  endtask

  task automatic checkOutputs(input string tag);
    check(32'(grantValid), 32'(mBusy), {tag, " grantValid"});
    if (mBusy) check(32'(grantChan), 32'(mChan), {tag, " grantChan"});
    check(32'(intStatus), 32'(mIntSt), {tag, " intStatus"});
    check(32'(irqValid), 32'(mIntSt != 0), {tag, " irqValid"});
    if (mIntSt != 0) check(32'(irqVector), 32'(expVector()), {tag, " irqVector"});
  endtask

  // drive one cycle of inputs, advance the model, check after the edge
  task automatic step(input logic [15:0] ev, input bit we, input logic [2:0] wa,
                      input logic [15:0] wd, input bit dn, input string tag);
    logic [15:0] clr, iset, hostSet, icl;
    bit          wasBusy;
    int          oldChan, lv, p;
    chanEvent = ev; wrEn = we; wrAddr = wa; wrData = wd; doneStb = dn;
    wasBusy = mBusy; oldChan = mChan; clr = '0; iset = '0;
    if (!wasBusy) begin
      lv = chooseLvl();
      if (lv > 0) begin
        p = pickFrom(lv);
        mBusy = 1; mChan = p; mLast[lv] = p; mSlot = (mSlot + 1) % 7;
      end
    end else if (dn) begin
      mBusy = 0;
      clr = 16'(1) << oldChan;
      if (mIntEn[oldChan]) iset = 16'(1) << oldChan;
    end
    hostSet = (we && wa == 3'd2) ? wd : '0;
    icl     = (we && wa == 3'd4) ? wd : '0;
    mPend  = (mPend & ~clr) | ev | hostSet;
    mIntSt = (mIntSt & ~icl) | iset;
    if (we) begin
      for (int c = 0; c < 16; c++)
        if (int'(wa) == c / 8) mPrio[c] = wd[2*(c%8) +: 2];
      if (wa == 3'd3) mIntEn = wd;
      if (wa == 3'd5) mBase = wd[3:0];
    end
    @(negedge clk);
    checkOutputs(tag);
  endtask

  task automatic idle(input int n, input bit serve, input string tag);
    for (int i = 0; i < n; i++) step('0, 0, '0, '0, serve && mBusy, tag);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cntLvl [4];
    int grantsSeen;
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkOutputs("R1");
    check(32'(irqVector), 32'h0, "R1 irqVector");

    // R2: all codes 00 -> requests latch but nothing is granted
    step(16'hFFFF, 0, '0, '0, 0, "R2");
    idle(4, 1, "R2 disabled");
    // enable ch8..15 at low level; latched requests now served
    step('0, 1, 3'd1, 16'h5555, 0, "R2 enable");
    idle(40, 1, "R2 served after enable");
    check(32'(mPend[7:0]), 32'hFF, "R2 disabled pending kept");

    // R3: ch0-3 high, ch4-7 mid, ch8-15 low, saturating load
    step('0, 1, 3'd0, 16'hAAFF, 0, "R3 prio");
    for (int l = 0; l < 4; l++) cntLvl[l] = 0;
    grantsSeen = 0;
    while (grantsSeen < 16) begin
      if (mBusy) begin
        if (grantsSeen >= 2) cntLvl[mPrio[mChan]]++;
        grantsSeen++;
      end
      step(16'hFFFF, 0, '0, '0, mBusy, "R3 round");
    end
    check(32'(cntLvl[3]), 32'd8, "R3 high slots");
    check(32'(cntLvl[2]), 32'd4, "R3 middle slots");
    check(32'(cntLvl[1]), 32'd2, "R3 low slots");
    idle(60, 1, "R3 drain");

    // R4: only low channels pending -> every slot goes to low
    step(16'h0300, 0, '0, '0, 0, "R4");
    idle(8, 1, "R4 fallback");
    // R5: high channels 1 and 3, round-robin order
    step(16'h000A, 0, '0, '0, 0, "R5");
    idle(8, 1, "R5 rr");

    // R6: host request write, and set colliding with clear
    step('0, 1, 3'd2, 16'h0010, 0, "R6 host");
    step('0, 0, '0, '0, 0, "R6 grant");
    check(32'(grantValid), 32'd1, "R6 host grant");
    step(16'h0010, 0, '0, '0, 1, "R6 collide");
    check(32'(mPend[4]), 32'd1, "R6 set wins");
    // R7: hold without done
    step('0, 0, '0, '0, 0, "R7 regrant");
    idle(5, 0, "R7 hold");
    idle(4, 1, "R7 release");

    // R8/R9: interrupts
    step('0, 1, 3'd3, 16'hFFFF, 0, "R8 enable");
    step('0, 1, 3'd5, 16'h000A, 0, "R9 base");
    step(16'h00C0, 0, '0, '0, 0, "R8");
    idle(8, 1, "R8 status");
    check(32'(intStatus[7:6]), 32'h3, "R8 both set");
    check(32'(irqVector), 32'hA6, "R9 vector");
    step('0, 1, 3'd4, 16'h0040, 0, "R8 clear");
    check(32'(irqVector), 32'hA7, "R9 next lowest");
    step('0, 1, 3'd4, 16'hFFFF, 0, "R8 clear all");
    check(32'(irqValid), 32'd0, "R9 no irq");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ev;
      bit we;
      ev = ($urandom % 6 == 0) ? 16'($urandom) : '0;
      we = ($urandom % 12 == 0);
      step(ev, we, 3'($urandom % 6), 16'($urandom), mBusy && ($urandom % 2 == 0),
           "R4 R5 random");
    end

    chanEvent = '0; wrEn = 0; doneStb = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule